// File: doc/BRIEF.md
# Reset Source Combiner with Cause Register

This block gathers every reset request in a chip into one system reset line and keeps a record of why the chip was reset. The requests are a power-on detect, a brown-out detect, an active-low master-clear pin, a software reset strobe, a watchdog expiry, a configuration mismatch, a trap conflict and three illegal-condition events. The three illegal-condition events are an illegal opcode, a read of a working register that was never written, and a security violation. The master-clear pin is filtered first, so that short glitches on it are ignored.

Any active source drives the system reset output at once. The output then stays high for a fixed number of clocks after the last source goes away. Each source sets its own flag in a cause register, and software reads that register after start-up. Power-on is the block's own asynchronous reset. It leaves only the power-on flag set.

Software may rewrite the flags through a simple write port. Writing only edits the record and never resets the chip. When a write and a reset event land in the same clock, the event's flag is still set.

Top module: `rst_cause_hub`

## Requirements
- R1: Any active non-power-on source drives `sys_rst` high in the same cycle. These sources are brown-out, filtered master clear, software strobe, watchdog, configuration mismatch, trap conflict and any illegal-condition event.
- R2: After the last source deasserts, `sys_rst` stays high for exactly HOLD_CYC (16) further clock edges. The same 16-edge hold follows the release of `por_evt`.
- R3: A source that is active at a clock edge sets its flag at that edge. The flag bits are: 1 brown-out, 3 watchdog, 4 software, 5 master clear, 6 configuration mismatch, 7 illegal condition, 8 trap conflict.
- R4: While `por_evt` is high, `bus_rdata` reads 0x0001 (only bit 0, the power-on flag, is set), every other flag is cleared and `sys_rst` is high.
- R5: A reset event never clears a flag. Flags from successive non-power-on events accumulate.
- R6: A write (`bus_wr` high at an edge) loads flag bits 0, 1 and 3..8 from `bus_wdata`. Bit 2 and bits 15..9 always read 0.
- R7: A write never asserts `sys_rst`.
- R8: The illegal-condition flag (bit 7) is set by any one of `illegal_opcode`, `uninit_wreg` or `security_viol`.
- R9: A low level on `mclr_pin_n` counts as a master-clear request only after it is sampled low at FILT_LEN (4) consecutive edges. A shorter low pulse sets no flag and asserts no reset.
- R10: When a write and a source hit the same edge, the source's flag is set whatever value is written to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_evt | input | 1 | Power-on detect, active high; also the block's asynchronous reset |
| bor_evt | input | 1 | Brown-out detect |
| mclr_pin_n | input | 1 | External master-clear pin, active low, unfiltered |
| swr_strobe | input | 1 | Software reset request |
| wdt_expire | input | 1 | Watchdog timeout |
| cfg_mismatch | input | 1 | Configuration mismatch |
| trap_conflict | input | 1 | Trap conflict |
| illegal_opcode | input | 1 | Illegal opcode event |
| uninit_wreg | input | 1 | Uninitialised working register used |
| security_viol | input | 1 | Security violation |
| bus_wr | input | 1 | Cause register write enable |
| bus_wdata | input | DATA_W | Cause register write data |
| bus_rdata | output | DATA_W | Cause register read data |
| sys_rst | output | 1 | Combined system reset, active high |

## Verification
A software write to the cause register and a reset source can fall in the same clock. The write tries to edit a flag while the event tries to set it. The bench provokes this directly: it writes all zeros in the same cycle as a watchdog strobe, and it lets its random phase issue writes and sources together at moderate rates. The flag of each firing source must read 1 at the next sample while the other bits take the written value. The bench also checks that the write by itself never raises `sys_rst`.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
   localparam int CAUSE_W = 9;
   localparam int B_POR   = 0;
   localparam int B_BOR   = 1;
   localparam int B_IDLE  = 2;
   localparam int B_WDT   = 3;
   localparam int B_SWR   = 4;
   localparam int B_MCLR  = 5;
   localparam int B_CFG   = 6;
   localparam int B_ILL   = 7;
   localparam int B_TRAP  = 8;

   typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_a,
   input  logic pin_n,
   output logic req
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   if (FILT_LEN < 1) begin : g_bad_len
      $error("rst_pin_filter: FILT_LEN must be at least 1");
   end

   if (FILT_LEN == 1) begin : g_single
      logic low_q;
      always_ff @(posedge clk or posedge rst_a) begin
         if (rst_a) low_q <= 1'b0;
         else       low_q <= ~pin_n;
      end
      assign req = low_q;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or posedge rst_a) begin
         if (rst_a)                         cnt_q <= '0;
         else if (pin_n)                    cnt_q <= '0;
         else if (cnt_q != CW'(FILT_LEN))   cnt_q <= cnt_q + 1'b1;
      end
      assign req = (cnt_q == CW'(FILT_LEN));
   end
endmodule

// File: rtl/rst_hold_stretch.sv
module rst_hold_stretch #(
   parameter int HOLD_CYC = 16
) (
   input  logic clk,
   input  logic rst_a,
   input  logic src_any,
   output logic rst_out
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("rst_hold_stretch: HOLD_CYC must be at least 1");
   end

   logic [HW-1:0] left_q;

   always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a)               left_q <= HW'(HOLD_CYC);
      else if (src_any)        left_q <= HW'(HOLD_CYC);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign rst_out = src_any | (left_q != '0);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_hub_pkg::*;
(
   input  logic   clk,
   input  logic   rst_a,
   input  cause_t ev,
   input  logic   wr,
   input  cause_t wdata,
   output cause_t q
);
   for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
      if (i == B_IDLE) begin : g_fixed
         logic unused_idle;
         assign unused_idle = ev[i] ^ wdata[i];
         assign q[i] = 1'b0;
      end else begin : g_flag
         always_ff @(posedge clk or posedge rst_a) begin
            if (rst_a) q[i] <= (i == B_POR);
            else       q[i] <= (wr ? wdata[i] : q[i]) | ev[i];
         end
      end
   end
endmodule

// File: rtl/rst_cause_hub.sv
module rst_cause_hub
   import rst_hub_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int FILT_LEN = 4,
   parameter int HOLD_CYC = 16
) (
   input  logic              clk,
   input  logic              por_evt,
   input  logic              bor_evt,
   input  logic              mclr_pin_n,
   input  logic              swr_strobe,
   input  logic              wdt_expire,
   input  logic              cfg_mismatch,
   input  logic              trap_conflict,
   input  logic              illegal_opcode,
   input  logic              uninit_wreg,
   input  logic              security_viol,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst
);
   if (DATA_W < CAUSE_W) begin : g_bad_width
      $error("rst_cause_hub: DATA_W must hold all cause flags");
   end

   logic   mclr_req;
   cause_t ev;
   cause_t cause_q;
   logic   src_any;

   rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_a (por_evt),
      .pin_n (mclr_pin_n),
      .req   (mclr_req)
   );

   always_comb begin
      ev         = '0;
      ev[B_BOR]  = bor_evt;
      ev[B_WDT]  = wdt_expire;
      ev[B_SWR]  = swr_strobe;
      ev[B_MCLR] = mclr_req;
      ev[B_CFG]  = cfg_mismatch;
      ev[B_ILL]  = illegal_opcode | uninit_wreg | security_viol;
      ev[B_TRAP] = trap_conflict;
   end

   assign src_any = |ev;

   rst_hold_stretch #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk     (clk),
      .rst_a   (por_evt),
      .src_any (src_any),
      .rst_out (sys_rst)
   );

   rst_cause_reg u_cause (
      .clk   (clk),
      .rst_a (por_evt),
      .ev    (ev),
      .wr    (bus_wr),
      .wdata (bus_wdata[CAUSE_W-1:0]),
      .q     (cause_q)
   );

   if (DATA_W > CAUSE_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:CAUSE_W];
      assign bus_rdata = {{(DATA_W-CAUSE_W){1'b0}}, cause_q};
   end else begin : g_exact
      assign bus_rdata = cause_q;
   end
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
   parameter int HOLD_CYC = 16
) (
   input logic       clk,
   input logic       por_evt,
   input logic       bor_evt,
   input logic       mclr_pin_n,
   input logic       swr_strobe,
   input logic       wdt_expire,
   input logic       cfg_mismatch,
   input logic       trap_conflict,
   input logic       illegal_opcode,
   input logic       uninit_wreg,
   input logic       security_viol,
   input logic       bus_wr,
   input logic       mclr_req,
   input logic [8:0] cause_q,
   input logic       sys_rst
);
   localparam int QW = $clog2(HOLD_CYC + 1);

   logic          any_ev;
   logic          ill_any;
   logic [QW-1:0] quiet_q;

   assign ill_any = illegal_opcode | uninit_wreg | security_viol;
   assign any_ev  = bor_evt | wdt_expire | swr_strobe | mclr_req |
                    cfg_mismatch | trap_conflict | ill_any;

   always_ff @(posedge clk or posedge por_evt) begin
      if (por_evt)                      quiet_q <= '0;
      else if (any_ev)                  quiet_q <= '0;
      else if (quiet_q != QW'(HOLD_CYC)) quiet_q <= quiet_q + 1'b1;
   end

   p_any_src_r1: assert property (@(posedge clk) disable iff (por_evt)
      any_ev |-> sys_rst);

   p_hold_window_r2: assert property (@(posedge clk) disable iff (por_evt)
      sys_rst == (any_ev || (quiet_q != QW'(HOLD_CYC))));

   p_wdt_flag_r3: assert property (@(posedge clk) disable iff (por_evt)
      wdt_expire |=> cause_q[3]);

   p_trap_flag_r3: assert property (@(posedge clk) disable iff (por_evt)
      trap_conflict |=> cause_q[8]);

   p_keep_flags_r5: assert property (@(posedge clk) disable iff (por_evt)
      !bus_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   p_write_quiet_r7: assert property (@(posedge clk) disable iff (por_evt)
      (bus_wr && !sys_rst) |=> (sys_rst == any_ev));

   p_ill_flag_r8: assert property (@(posedge clk) disable iff (por_evt)
      ill_any |=> cause_q[7]);

   p_pin_low_r9: assert property (@(posedge clk) disable iff (por_evt)
      mclr_req |-> !$past(mclr_pin_n));

   p_event_wins_r10: assert property (@(posedge clk) disable iff (por_evt)
      (bus_wr && swr_strobe) |=> cause_q[4]);
endmodule

bind rst_cause_hub rst_hub_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk            (clk),
   .por_evt        (por_evt),
   .bor_evt        (bor_evt),
   .mclr_pin_n     (mclr_pin_n),
   .swr_strobe     (swr_strobe),
   .wdt_expire     (wdt_expire),
   .cfg_mismatch   (cfg_mismatch),
   .trap_conflict  (trap_conflict),
   .illegal_opcode (illegal_opcode),
   .uninit_wreg    (uninit_wreg),
   .security_viol  (security_viol),
   .bus_wr         (bus_wr),
   .mclr_req       (mclr_req),
   .cause_q        (cause_q),
   .sys_rst        (sys_rst)
);

// File: tb/sim_rst_cause_hub.sv
module sim_rst_cause_hub;
   localparam int CLK_PER = 10;
   localparam int DW      = 16;
   localparam int FL      = 4;
   localparam int HC      = 16;

   logic clk = 1'b0;
   logic por_evt = 1'b1, bor_evt = 1'b0, mclr_pin_n = 1'b1, swr_strobe = 1'b0;
   logic wdt_expire = 1'b0, cfg_mismatch = 1'b0, trap_conflict = 1'b0;
   logic illegal_opcode = 1'b0, uninit_wreg = 1'b0, security_viol = 1'b0;
   logic bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic sys_rst;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   rst_cause_hub #(.DATA_W(DW), .FILT_LEN(FL), .HOLD_CYC(HC)) u0 (
      .clk(clk), .por_evt(por_evt), .bor_evt(bor_evt), .mclr_pin_n(mclr_pin_n),
      .swr_strobe(swr_strobe), .wdt_expire(wdt_expire), .cfg_mismatch(cfg_mismatch),
      .trap_conflict(trap_conflict), .illegal_opcode(illegal_opcode),
      .uninit_wreg(uninit_wreg), .security_viol(security_viol), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst)
   );

   // reference state built from the requirements
   logic [8:0] m_cause;
   int m_low, m_hold;

   function automatic logic [8:0] events(int low_cnt);
      logic [8:0] e = '0;
      e[1] = bor_evt;
      e[3] = wdt_expire;
      e[4] = swr_strobe;
      e[5] = (low_cnt >= FL);
      e[6] = cfg_mismatch;
      e[7] = illegal_opcode | uninit_wreg | security_viol;
      e[8] = trap_conflict;
      return e;
   endfunction

   function automatic logic [8:0] write_mask(logic [DW-1:0] d);
      return d[8:0] & 9'b1_1111_1011;
   endfunction

   always @(posedge clk or posedge por_evt) begin
      if (por_evt) begin
         m_cause <= 9'h001;
         m_low   <= 0;
         m_hold  <= HC;
      end else begin
         m_cause <= (bus_wr ? write_mask(bus_wdata) : m_cause) | events(m_low);
         m_low   <= mclr_pin_n ? 0 : ((m_low < FL) ? m_low + 1 : FL);
         m_hold  <= (|events(m_low)) ? HC : ((m_hold > 0) ? m_hold - 1 : 0);
      end
   end

   function automatic logic exp_rst();
      return por_evt | (|events(m_low)) | (m_hold != 0);
   endfunction

   task automatic check(string req);
      logic [DW-1:0] er;
      logic es;
      er = {{(DW-9){1'b0}}, m_cause};
      es = exp_rst();
      n_chk++;
      if (bus_rdata !== er || sys_rst !== es) begin
         n_bad++;
         $display("FAIL %s: rdata=%h sys_rst=%b expected rdata=%h sys_rst=%b",
                  req, bus_rdata, sys_rst, er, es);
      end
   endtask

   // one clock: inputs already set at a falling edge, check after the rising edge
   task automatic step(string req);
      @(posedge clk);
      #1 check(req);
      @(negedge clk);
   endtask

   task automatic quiet();
      bor_evt = 0; swr_strobe = 0; wdt_expire = 0; cfg_mismatch = 0;
      trap_conflict = 0; illegal_opcode = 0; uninit_wreg = 0; security_viol = 0;
      bus_wr = 0; mclr_pin_n = 1;
   endtask

   task automatic wr(logic [DW-1:0] d);
      bus_wr = 1; bus_wdata = d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7331));
      @(negedge clk);
      // R4: reset state, write ignored while power-on is held
      step("R4");
      wr(16'hFFFF); step("R4");
      quiet();
      por_evt = 0;
      // R2: hold after power-on release
      for (int i = 0; i < HC + 3; i++) step("R2");

      // R6: clear by write
      wr(16'h0000); step("R6"); quiet();
      // R1/R3 each source alone
      bor_evt = 1; step("R1"); quiet(); step("R3");
      for (int i = 0; i < HC; i++) step("R2");
      wr(0); step("R6"); quiet();
      cfg_mismatch = 1; step("R3"); quiet();
      for (int i = 0; i < HC; i++) step("R2");
      // R5: accumulate
      wdt_expire = 1; step("R5"); quiet();
      trap_conflict = 1; step("R5"); quiet();
      swr_strobe = 1; step("R5"); quiet();
      for (int i = 0; i < HC + 2; i++) step("R2");
      // R6: unused bits read 0; R7: write alone keeps reset low
      wr(16'hFFFF); step("R6"); quiet(); step("R7");
      wr(16'h0004); step("R6"); quiet(); step("R7");
      // R8: each illegal event
      illegal_opcode = 1; step("R8"); quiet();
      wr(0); step("R8"); quiet();
      uninit_wreg = 1; step("R8"); quiet();
      wr(0); step("R8"); quiet();
      security_viol = 1; step("R8"); quiet();
      for (int i = 0; i < HC; i++) step("R2");
      wr(0); step("R6"); quiet();
      // R9: three-low pulse is ignored, four-low is accepted
      mclr_pin_n = 0;
      for (int i = 0; i < FL - 1; i++) step("R9");
      mclr_pin_n = 1; step("R9"); step("R9");
      mclr_pin_n = 0;
      for (int i = 0; i < FL + 2; i++) step("R9");
      mclr_pin_n = 1;
      for (int i = 0; i < HC + 2; i++) step("R2");
      // R10: write zero in the same cycle as a watchdog strobe
      wr(16'h0000); wdt_expire = 1; step("R10"); quiet(); step("R10");
      wr(16'h0000); trap_conflict = 1; swr_strobe = 1; step("R10"); quiet();
      // R4: power-on wipes accumulated flags
      por_evt = 1; step("R4"); step("R4");
      por_evt = 0; quiet();
      for (int i = 0; i < HC + 2; i++) step("R2");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bor_evt        = ($urandom_range(0, 99) < 2);
         swr_strobe     = ($urandom_range(0, 99) < 2);
         wdt_expire     = ($urandom_range(0, 99) < 2);
         cfg_mismatch   = ($urandom_range(0, 99) < 1);
         trap_conflict  = ($urandom_range(0, 99) < 1);
         illegal_opcode = ($urandom_range(0, 99) < 1);
         uninit_wreg    = ($urandom_range(0, 99) < 1);
         security_viol  = ($urandom_range(0, 99) < 1);
         if ($urandom_range(0, 99) < 15) mclr_pin_n = ~mclr_pin_n;
         bus_wr         = ($urandom_range(0, 99) < 10);
         bus_wdata      = DW'($urandom);
         if (($urandom_range(0, 999) < 3) && !por_evt) por_evt = 1;
         else por_evt = 0;
         step("R3");
      end
      quiet(); por_evt = 0;
      for (int i = 0; i < HC + 2; i++) step("R2");
      finish_run();
   end
endmodule